// File: doc/BRIEF.md
# Control-Register Access Unit

This block sits in front of a core's control and status registers and handles every register instruction. Each request carries a 12-bit register number, the current privilege level, a debugger-access flag, a new value and a write mask. The unit decodes the access rights from the register number, applies the availability rule for the selected register, and reads the current contents. If the access is legal and the mask is non-zero, it writes back the masked merge of old and new. One cycle later it returns the old contents, or it flags the access as illegal.

The three instruction forms reduce to one masked merge, so the caller only picks the value and the mask. Read-write passes the source operand as the value and all ones as the mask. Set passes all ones as the value and the operand as the mask. Clear passes zero as the value and the operand as the mask. A plain read passes a zero mask. The registers behind the unit are a small internal set: floating-point exception flags and rounding mode, a scratch register for each of the supervisor and machine levels, the two counter-enable gates, stub counters and an identity register.

Top module: `csr_access_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `rsp_valid` is 0. All writable state clears to zero, so every mapped writable register reads 0 after reset.
- R2: Each cycle with `req_valid` high produces exactly one response with `rsp_valid` high on the next cycle. With no request there is no response.
- R3: Privilege is encoded U=0, S=1, M=3. Register number bits 9:8 give the minimum privilege. An access made with `req_priv` below that level is illegal unless `req_dbg` is 1.
- R4: A register whose number bits 11:10 are both 1 is read-only. Any access to it with a non-zero mask is illegal. A zero-mask read of it is legal.
- R5: A legal access with a non-zero mask stores `(old & ~mask) | (value & mask)`. A zero mask stores nothing.
- R6: A legal access returns the register contents from before the access in `rsp_rdata`.
- R7: An illegal access changes no register state and returns `rsp_illegal`=1 with `rsp_rdata`=0.
- R8: A register number outside the map in R12 is illegal for every privilege level.
- R9: Counters occupy 0xC00–0xC1F and read as zero. When `cfg_legacy_ctr` is 1, a U access needs the bit indexed by number bits 4:0 set in both the machine gate and the supervisor gate. An S access needs only the machine gate bit, and an M access is always allowed. When `cfg_legacy_ctr` is 0, counters are always available.
- R10: The floating-point registers (0x001, 0x002, 0x003) are illegal when `cfg_fp_on` is 0, unless `req_dbg` is 1.
- R11: 0x001 holds 5 flag bits and 0x002 holds 3 rounding bits. 0x003 reads as {rounding, flags} in bits 7:0, and a write to 0x003 splits bits 7:5 into the rounding field and bits 4:0 into the flags. All other bits read 0.
- R12: The map is as follows. Machine level: 0x340 is the scratch register, 0x306 is the counter gate, and 0xF14 is a read-only identity register that returns `HART_ID`. Supervisor level: 0x140 is the scratch register and 0x106 is the counter gate. The floating-point registers and counters are given in R10, R11 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register number |
| req_priv | input | 2 | Current privilege level (U=0, S=1, M=3) |
| req_dbg | input | 1 | Debugger access, bypasses privilege and floating-point gating |
| req_wdata | input | XLEN | New value for the masked merge |
| req_wmask | input | XLEN | Write mask; zero means read only |
| cfg_fp_on | input | 1 | Floating-point state enabled |
| cfg_legacy_ctr | input | 1 | Counter access gated by the enable registers |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | XLEN | Old register contents, zero when illegal |
| rsp_illegal | output | 1 | Access rejected |

## Verification
The checks assume that `req_priv` never takes the reserved value 2. They also assume that request fields are meaningful only while `req_valid` is high, and that the configuration inputs are sampled with the request they accompany. The stimulus drives only the three defined privilege codes, changes every input half a cycle away from the active edge, and holds all request fields together for exactly one cycle per access. Back-to-back requests occur only in a directed test, and there the ordering of write and following read is the property under test.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam int FLAG_W   = 5;
  localparam int RND_W    = 3;
  localparam int GATE_IDX_W = 5;

  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;

  localparam logic [11:0] A_FP_FLAGS = 12'h001;
  localparam logic [11:0] A_FP_RND   = 12'h002;
  localparam logic [11:0] A_FP_ALL   = 12'h003;
  localparam logic [11:0] A_S_GATE   = 12'h106;
  localparam logic [11:0] A_S_SCR    = 12'h140;
  localparam logic [11:0] A_M_GATE   = 12'h306;
  localparam logic [11:0] A_M_SCR    = 12'h340;
  localparam logic [11:0] A_ID       = 12'hF14;
  localparam logic [6:0]  A_CTR_HI   = 7'b1100_000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FFLAG, SEL_FRND, SEL_FALL,
    SEL_SSCR, SEL_MSCR, SEL_SGATE, SEL_MGATE,
    SEL_CTR,  SEL_ID
  } reg_sel_e;

  typedef enum logic [1:0] {
    PRED_NONE, PRED_ANY, PRED_FP, PRED_CTR
  } pred_e;

  function automatic logic [1:0] f_min_level(input logic [11:0] a);
    return a[9:8];
  endfunction

  function automatic logic f_is_ro(input logic [11:0] a);
    return a[11:10] == 2'b11;
  endfunction

  function automatic logic [GATE_IDX_W-1:0] f_gate_idx(input logic [11:0] a);
    return a[GATE_IDX_W-1:0];
  endfunction

  function automatic logic [63:0] f_merge(input logic [63:0] old_v,
                                          input logic [63:0] new_v,
                                          input logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_unit_pkg::*;
(
  input  logic [11:0] addr,
  output reg_sel_e    sel,
  output pred_e       pred
);
  always_comb begin
    sel  = SEL_NONE;
    pred = PRED_NONE;
    if (addr[11:5] == A_CTR_HI) begin
      sel  = SEL_CTR;
      pred = PRED_CTR;
    end else begin
      unique case (addr)
        A_FP_FLAGS: begin sel = SEL_FFLAG; pred = PRED_FP;  end
        A_FP_RND:   begin sel = SEL_FRND;  pred = PRED_FP;  end
        A_FP_ALL:   begin sel = SEL_FALL;  pred = PRED_FP;  end
        A_S_SCR:    begin sel = SEL_SSCR;  pred = PRED_ANY; end
        A_M_SCR:    begin sel = SEL_MSCR;  pred = PRED_ANY; end
        A_S_GATE:   begin sel = SEL_SGATE; pred = PRED_ANY; end
        A_M_GATE:   begin sel = SEL_MGATE; pred = PRED_ANY; end
        A_ID:       begin sel = SEL_ID;    pred = PRED_ANY; end
        default:    begin sel = SEL_NONE;  pred = PRED_NONE; end
      endcase
    end
  end
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]            min_level,
  input  logic                  ro,
  input  logic [GATE_IDX_W-1:0] gate_idx,
  input  logic [1:0]            priv,
  input  logic                  dbg,
  input  logic                  wmask_nz,
  input  logic                  fp_on,
  input  logic                  legacy_ctr,
  input  pred_e                 pred,
  input  logic [XLEN-1:0]       m_gate,
  input  logic [XLEN-1:0]       s_gate,
  output logic                  priv_fail,
  output logic                  ro_fail,
  output logic                  pred_fail,
  output logic                  illegal
);
  logic ctr_ok;

  always_comb begin
    ctr_ok = 1'b1;
    if (legacy_ctr) begin
      if (priv < LVL_M) ctr_ok = ctr_ok & m_gate[gate_idx];
      if (priv < LVL_S) ctr_ok = ctr_ok & s_gate[gate_idx];
    end
  end

  always_comb begin
    priv_fail = !dbg && (priv < min_level);
    ro_fail   = ro && wmask_nz;
    unique case (pred)
      PRED_ANY: pred_fail = 1'b0;
      PRED_FP:  pred_fail = !dbg && !fp_on;
      PRED_CTR: pred_fail = !ctr_ok;
      default:  pred_fail = 1'b1;
    endcase
    illegal = priv_fail | ro_fail | pred_fail;
  end
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_unit_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0000_0007
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  reg_sel_e        sel,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] rval,
  output logic [FLAG_W-1:0] flags_q,
  output logic [RND_W-1:0]  rnd_q,
  output logic [XLEN-1:0] s_scr_q,
  output logic [XLEN-1:0] m_scr_q,
  output logic [XLEN-1:0] s_gate_q,
  output logic [XLEN-1:0] m_gate_q
);
  localparam int N_WORD = 4;
  localparam reg_sel_e WORD_SEL [N_WORD] = '{SEL_SSCR, SEL_MSCR, SEL_SGATE, SEL_MGATE};

  logic [XLEN-1:0] word_q [N_WORD];

  for (genvar g = 0; g < N_WORD; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         word_q[g] <= '0;
      else if (we && sel == WORD_SEL[g])  word_q[g] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      rnd_q   <= '0;
    end else if (we) begin
      if (sel == SEL_FFLAG || sel == SEL_FALL) flags_q <= wval[FLAG_W-1:0];
      if (sel == SEL_FRND)  rnd_q <= wval[RND_W-1:0];
      if (sel == SEL_FALL)  rnd_q <= wval[FLAG_W+RND_W-1:FLAG_W];
    end
  end

  assign s_scr_q  = word_q[0];
  assign m_scr_q  = word_q[1];
  assign s_gate_q = word_q[2];
  assign m_gate_q = word_q[3];

  always_comb begin
    rval = '0;
    unique case (sel)
      SEL_FFLAG: rval[FLAG_W-1:0] = flags_q;
      SEL_FRND:  rval[RND_W-1:0]  = rnd_q;
      SEL_FALL:  rval[FLAG_W+RND_W-1:0] = {rnd_q, flags_q};
      SEL_SSCR:  rval = s_scr_q;
      SEL_MSCR:  rval = m_scr_q;
      SEL_SGATE: rval = s_gate_q;
      SEL_MGATE: rval = m_gate_q;
      SEL_ID:    rval[31:0] = HART_ID;
      default:   rval = '0;
    endcase
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0000_0007
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_priv,
  input  logic            req_dbg,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [XLEN-1:0] req_wmask,
  input  logic            cfg_fp_on,
  input  logic            cfg_legacy_ctr,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            rsp_illegal
);
  localparam int SNAP_W = FLAG_W + RND_W + 4*XLEN;

  reg_sel_e        sel;
  pred_e           pred;
  logic            priv_fail, ro_fail, pred_fail, acc_illegal;
  logic            wmask_nz;
  logic            ev_write;
  logic [XLEN-1:0] old_val, new_val;
  logic [FLAG_W-1:0] flags_q;
  logic [RND_W-1:0]  rnd_q;
  logic [XLEN-1:0] s_scr_q, m_scr_q, s_gate_q, m_gate_q;
  logic [SNAP_W-1:0] st_snapshot;
  logic [63:0]     merge_full;

  assign wmask_nz = |req_wmask;

  csr_addr_decode u_dec (
    .addr (req_addr),
    .sel  (sel),
    .pred (pred)
  );

  csr_access_check #(.XLEN(XLEN)) u_chk_acc (
    .min_level  (f_min_level(req_addr)),
    .ro         (f_is_ro(req_addr)),
    .gate_idx   (f_gate_idx(req_addr)),
    .priv       (req_priv),
    .dbg        (req_dbg),
    .wmask_nz   (wmask_nz),
    .fp_on      (cfg_fp_on),
    .legacy_ctr (cfg_legacy_ctr),
    .pred       (pred),
    .m_gate     (m_gate_q),
    .s_gate     (s_gate_q),
    .priv_fail  (priv_fail),
    .ro_fail    (ro_fail),
    .pred_fail  (pred_fail),
    .illegal    (acc_illegal)
  );

  assign merge_full = f_merge(64'(old_val), 64'(req_wdata), 64'(req_wmask));
  assign new_val    = merge_full[XLEN-1:0];
  assign ev_write   = req_valid && !acc_illegal && wmask_nz;

  csr_store #(.XLEN(XLEN), .HART_ID(HART_ID)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ev_write),
    .sel      (sel),
    .wval     (new_val),
    .rval     (old_val),
    .flags_q  (flags_q),
    .rnd_q    (rnd_q),
    .s_scr_q  (s_scr_q),
    .m_scr_q  (m_scr_q),
    .s_gate_q (s_gate_q),
    .m_gate_q (m_gate_q)
  );

  assign st_snapshot = {flags_q, rnd_q, s_scr_q, m_scr_q, s_gate_q, m_gate_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && acc_illegal;
      rsp_rdata   <= (req_valid && !acc_illegal) ? old_val : '0;
    end
  end
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
  parameter int XLEN   = 32,
  parameter int SNAP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [11:0]       req_addr,
  input logic [1:0]        req_priv,
  input logic              req_dbg,
  input logic [XLEN-1:0]   req_wmask,
  input logic              cfg_fp_on,
  input logic              rsp_valid,
  input logic              rsp_illegal,
  input logic [XLEN-1:0]   rsp_rdata,
  input logic              ev_write,
  input logic [SNAP_W-1:0] st_snapshot
);
  logic is_fp_addr;
  assign is_fp_addr = (req_addr == 12'h001) || (req_addr == 12'h002) || (req_addr == 12'h003);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_priv_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dbg && (req_priv < req_addr[9:8])) |=> rsp_illegal);

  assert_ro_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[11:10] == 2'b11) && (req_wmask != '0)) |=> rsp_illegal);

  assert_fp_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dbg && !cfg_fp_on && is_fp_addr) |=> rsp_illegal);

  assert_read_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_wmask == '0)) |=> $stable(st_snapshot));

  assert_write_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |-> (req_valid && (req_wmask != '0)));

  assert_illegal_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> $stable(st_snapshot));

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (rsp_rdata == '0 && rsp_valid));
endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN), .SNAP_W(SNAP_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_priv    (req_priv),
  .req_dbg     (req_dbg),
  .req_wmask   (req_wmask),
  .cfg_fp_on   (cfg_fp_on),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .rsp_rdata   (rsp_rdata),
  .ev_write    (ev_write),
  .st_snapshot (st_snapshot)
);

// File: tb/tb_csr_access_unit.sv
module tb_csr_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int VW = 122;
  localparam int NV = 34;

  // entry: {req_no[7:0], addr[11:0], priv[1:0], dbg, fp_on, legacy, wdata[31:0], wmask[31:0], exp_ill, exp_rdata[31:0]}
  function automatic logic [VW-1:0] v(input logic [7:0] rq, input logic [11:0] a,
      input logic [1:0] p, input logic d, input logic f, input logic l,
      input logic [31:0] wd, input logic [31:0] wm, input logic ei, input logic [31:0] er);
    return {rq, a, p, d, f, l, wd, wm, ei, er};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(5,  12'h340, 2'd3, 0, 1, 0, 32'hDEADBEEF, 32'hFFFFFFFF, 0, 32'h0),        // R5 read-write form
    v(6,  12'h340, 2'd3, 0, 1, 0, 32'h0,        32'h0,        0, 32'hDEADBEEF), // R6
    v(5,  12'h340, 2'd3, 0, 1, 0, 32'hFFFFFFFF, 32'h00000010, 0, 32'hDEADBEEF), // R5 set form
    v(5,  12'h340, 2'd3, 0, 1, 0, 32'h0,        32'hFF000000, 0, 32'hDEADBEFF), // R5 clear form
    v(6,  12'h340, 2'd3, 0, 1, 0, 32'h0,        32'h0,        0, 32'h00ADBEFF), // R6
    v(3,  12'h340, 2'd1, 0, 1, 0, 32'h11111111, 32'hFFFFFFFF, 1, 32'h0),        // R3 S below M
    v(7,  12'h340, 2'd1, 1, 1, 0, 32'h0,        32'h0,        0, 32'h00ADBEFF), // R7 unchanged, R3 debugger bypass
    v(3,  12'h140, 2'd1, 0, 1, 0, 32'h12345678, 32'hFFFFFFFF, 0, 32'h0),        // R3 S at S
    v(3,  12'h140, 2'd0, 0, 1, 0, 32'h0,        32'h0,        1, 32'h0),        // R3 U below S
    v(3,  12'h140, 2'd3, 0, 1, 0, 32'h0,        32'h0,        0, 32'h12345678), // R3 M above S
    v(12, 12'hF14, 2'd3, 0, 1, 0, 32'h0,        32'h0,        0, 32'h00000007), // R12 identity
    v(4,  12'hF14, 2'd3, 0, 1, 0, 32'h0,        32'h00000001, 1, 32'h0),        // R4 write to read-only
    v(3,  12'hF14, 2'd0, 0, 1, 0, 32'h0,        32'h0,        1, 32'h0),        // R3 U to M register
    v(10, 12'h001, 2'd0, 0, 0, 0, 32'h0000001F, 32'hFFFFFFFF, 1, 32'h0),        // R10 fp off
    v(11, 12'h001, 2'd0, 0, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 32'h0),        // R11 flags (R7: previous left 0)
    v(11, 12'h002, 2'd0, 0, 1, 0, 32'hFFFFFFF5, 32'hFFFFFFFF, 0, 32'h0),        // R11 rounding
    v(10, 12'h003, 2'd0, 1, 0, 0, 32'h0,        32'h0,        0, 32'h000000BF), // R10 debugger bypass, R11 combined
    v(11, 12'h003, 2'd0, 0, 1, 0, 32'h0,        32'h00000021, 0, 32'h000000BF), // R11 split write
    v(11, 12'h001, 2'd0, 0, 1, 0, 32'h0,        32'h0,        0, 32'h0000001E), // R11
    v(11, 12'h002, 2'd0, 0, 1, 0, 32'h0,        32'h0,        0, 32'h00000004), // R11
    v(8,  12'h7FF, 2'd3, 0, 1, 0, 32'h0,        32'h0,        1, 32'h0),        // R8 unmapped
    v(8,  12'h341, 2'd3, 1, 1, 0, 32'h0,        32'h0,        1, 32'h0),        // R8 unmapped with debugger
    v(9,  12'h306, 2'd3, 0, 1, 0, 32'h00000005, 32'hFFFFFFFF, 0, 32'h0),        // R9 machine gate
    v(9,  12'h106, 2'd1, 0, 1, 0, 32'h00000001, 32'hFFFFFFFF, 0, 32'h0),        // R9 supervisor gate
    v(9,  12'hC00, 2'd0, 0, 1, 1, 32'h0,        32'h0,        0, 32'h0),        // R9 U both bits set
    v(9,  12'hC02, 2'd0, 0, 1, 1, 32'h0,        32'h0,        1, 32'h0),        // R9 U supervisor bit clear
    v(9,  12'hC02, 2'd1, 0, 1, 1, 32'h0,        32'h0,        0, 32'h0),        // R9 S machine bit set
    v(9,  12'hC01, 2'd1, 0, 1, 1, 32'h0,        32'h0,        1, 32'h0),        // R9 S machine bit clear
    v(9,  12'hC01, 2'd3, 0, 1, 1, 32'h0,        32'h0,        0, 32'h0),        // R9 M always
    v(9,  12'hC01, 2'd0, 0, 1, 0, 32'h0,        32'h0,        0, 32'h0),        // R9 newer rule
    v(9,  12'hC1F, 2'd0, 0, 1, 1, 32'h0,        32'h0,        1, 32'h0),        // R9 index 31
    v(4,  12'hC00, 2'd3, 0, 1, 0, 32'h0,        32'h00000001, 1, 32'h0),        // R4 counter write
    v(6,  12'h306, 2'd3, 0, 1, 0, 32'h0,        32'h0,        0, 32'h00000005), // R6
    v(6,  12'h106, 2'd1, 0, 1, 0, 32'h0,        32'h0,        0, 32'h00000001)  // R6
  };

  logic            clk = 0;
  logic            rst_n = 0;
  logic            req_valid = 0;
  logic [11:0]     req_addr = '0;
  logic [1:0]      req_priv = '0;
  logic            req_dbg = 0;
  logic [XLEN-1:0] req_wdata = '0;
  logic [XLEN-1:0] req_wmask = '0;
  logic            cfg_fp_on = 0;
  logic            cfg_legacy_ctr = 0;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_rdata;
  logic            rsp_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_access_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_dbg(req_dbg), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .cfg_fp_on(cfg_fp_on), .cfg_legacy_ctr(cfg_legacy_ctr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  task automatic check(input string tag, input logic [XLEN+1:0] act, input logic [XLEN+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (valid,illegal,rdata)", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic d,
                       input logic f, input logic l, input logic [31:0] wd, input logic [31:0] wm);
    req_valid = 1; req_addr = a; req_priv = p; req_dbg = d;
    cfg_fp_on = f; cfg_legacy_ctr = l; req_wdata = wd; req_wmask = wm;
  endtask

  task automatic idle();
    req_valid = 0; req_wmask = '0; req_wdata = '0; req_dbg = 0;
  endtask

  task automatic access(input string tag, input logic [11:0] a, input logic [1:0] p,
      input logic d, input logic f, input logic l, input logic [31:0] wd,
      input logic [31:0] wm, input logic ei, input logic [31:0] er);
    @(negedge clk);
    drive(a, p, d, f, l, wd, wm);
    @(negedge clk);
    idle();
    check(tag, {rsp_valid, rsp_illegal, rsp_rdata}, {1'b1, ei, er});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 no response in reset", {rsp_valid, 1'b0, 32'h0}, {1'b0, 1'b0, 32'h0});
    rst_n = 1;
    @(negedge clk);
    check("R1 no response after reset", {rsp_valid, rsp_illegal, rsp_rdata}, '0);
    access("R1 machine scratch clear", 12'h340, 2'd3, 0, 1, 0, 0, 0, 0, 32'h0);
    access("R1 fp flags clear", 12'h001, 2'd0, 0, 1, 0, 0, 0, 0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vector %0d", e[121:114], i);
      access(tag, e[113:102], e[101:100], e[99], e[98], e[97],
             e[96:65], e[64:33], e[32], e[31:0]);
    end

    // R2 / R6: back-to-back write then read
    @(negedge clk);
    drive(12'h340, 2'd3, 0, 1, 0, 32'hCAFEF00D, 32'hFFFFFFFF);
    @(negedge clk);
    check("R2 first of pair", {rsp_valid, rsp_illegal, rsp_rdata}, {1'b1, 1'b0, 32'h00ADBEFF});
    drive(12'h340, 2'd3, 0, 1, 0, 32'h0, 32'h0);
    @(negedge clk);
    idle();
    check("R6 second of pair sees write", {rsp_valid, rsp_illegal, rsp_rdata}, {1'b1, 1'b0, 32'hCAFEF00D});
    @(negedge clk);
    check("R2 idle gives no response", {rsp_valid, rsp_illegal, rsp_rdata}, '0);

    // R1: reset in the middle of a run
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 no response after second reset", {rsp_valid, rsp_illegal, rsp_rdata}, '0);
    access("R1 machine scratch cleared again", 12'h340, 2'd3, 0, 1, 0, 0, 0, 0, 32'h0);
    access("R1 supervisor gate cleared", 12'h106, 2'd1, 0, 1, 0, 0, 0, 0, 32'h0);
    access("R1 combined fp cleared", 12'h003, 2'd0, 0, 1, 0, 0, 0, 0, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule